// File: doc/BRIEF.md
# Oversampled Timing Sampler with Glitch Flags

This block is the acquisition front end of a timing-mode capture path. Every input channel is watched on each cycle of a fast sampling clock, and once per programmable sample period the block emits a snapshot of all channels together with a sample-valid strobe. The period is an integer count of fast-clock cycles.

Between two sample points each channel keeps a saturating count of the level changes it sees, cycle by cycle, on a path separate from the snapshot register. At a sample point this count is compared with the change between the previous snapshot and the new one. A channel that toggled more often than its net change shows is flagged as a glitch in the same snapshot, so a pulse narrower than the sample period is never lost. Inputs are assumed to be already synchronised to the fast clock.

Top module: `tsamp_top`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `smp_valid`, `smp_data` and `smp_glitch` are all zero.
- R2: With period register value P (a value of 0 acts as 1), `smp_valid` is high for exactly one cycle every P fast-clock cycles. The first strobe follows the P-th rising edge after reset release.
- R3: At each strobe, bit i of `smp_data` equals the level of `din[i]` at the sample edge.
- R4: A channel that made exactly one transition in the period, so that its sampled value changed, has its `smp_glitch` bit low.
- R5: A channel whose sampled value equals the previous sample but which made at least one transition in the period has its `smp_glitch` bit high.
- R6: A channel whose sampled value changed and which made two or more transitions in the period (for example 0,1,0,1) reports the new value with its `smp_glitch` bit high.
- R7: A transition that occurs exactly at a sample edge belongs to the period that this edge closes. It does not count toward the following period.
- R8: When the effective period is 1, every `smp_glitch` bit is zero.
- R9: The first strobe after reset has all `smp_glitch` bits zero. It only sets the reference value.
- R10: Channels are independent: the glitch bit and data bit of one channel depend only on that channel's input.
- R11: Between strobes, `smp_data` and `smp_glitch` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | PER_W | Sample period in fast-clock cycles (0 acts as 1) |
| din | input | NCH | Channel inputs, synchronous to `clk` |
| smp_valid | output | 1 | One-cycle strobe per sample period |
| smp_data | output | NCH | Snapshot of the channels at the last sample edge |
| smp_glitch | output | NCH | Per-channel glitch flags for the last snapshot |

## Verification
The embedded assertions check on every cycle the rules that are local in time. They cover the strobe following the divider tick, the spacing of ticks, the holding of outputs between strobes, the clean first sample and the forced-low flags at period 1. They also check that a lone transition never raises a flag and that an unchanged channel with recorded activity always does. Only the bench scenarios can show that whole input sequences map to the right snapshots and flags. These include pulses inside a period, transitions landing exactly on a sample edge, odd transition counts larger than one, independent channel mixes and period changes including the zero setting. In each case the expected flags come from counting level changes over the driven sequence.

// File: rtl/tsamp_pkg.sv
package tsamp_pkg;
  localparam int HIT_W = 2;
  typedef logic [HIT_W-1:0] hit_t;

  // saturating increment of the per-period transition count
  function automatic hit_t sat_inc(input hit_t acc, input logic inc);
    if (!inc) return acc;
    if (acc == {HIT_W{1'b1}}) return acc;
    return acc + hit_t'(1);
  endfunction

  // glitch rule: extra activity beyond the net change of the sampled level
  function automatic logic glitch_fn(input logic changed, input hit_t hits);
    if (changed) return (hits >= hit_t'(2));
    return (hits != hit_t'(0));
  endfunction
endpackage

// File: rtl/tsamp_divider.sv
module tsamp_divider #(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             tick,
  output logic             per_one
);
  function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
    return (p == '0) ? {{(PER_W-1){1'b0}}, 1'b1} : p;
  endfunction

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] eff_per;

  assign eff_per = eff_period(period);
  assign per_one = (eff_per == {{(PER_W-1){1'b0}}, 1'b1});
  assign tick    = (cnt_q >= eff_per - {{(PER_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + {{(PER_W-1){1'b0}}, 1'b1};
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || per_one));
endmodule

// File: rtl/tsamp_chan.sv
module tsamp_chan
  import tsamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din_bit,
  input  logic tick,
  input  logic mask,
  output logic smp_bit,
  output logic glitch_bit
);
  logic last_q;
  hit_t acc_q;
  hit_t hits_now;
  logic step_now;
  logic changed;

  assign step_now = din_bit ^ last_q;
  assign hits_now = sat_inc(acc_q, step_now);
  assign changed  = din_bit ^ smp_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= 1'b0;
      acc_q      <= '0;
      smp_bit    <= 1'b0;
      glitch_bit <= 1'b0;
    end else begin
      last_q <= din_bit;
      if (tick) begin
        acc_q      <= '0;
        smp_bit    <= din_bit;
        glitch_bit <= mask ? 1'b0 : glitch_fn(changed, hits_now);
      end else begin
        acc_q <= hits_now;
      end
    end
  end

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && changed && hits_now == hit_t'(1)) |=> !glitch_bit);

  // R5
  hidden_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mask && !changed && hits_now != hit_t'(0)) |=> glitch_bit);
endmodule

// File: rtl/tsamp_top.sv
module tsamp_top #(
  parameter int NCH   = 4,
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic [NCH-1:0]   din,
  output logic             smp_valid,
  output logic [NCH-1:0]   smp_data,
  output logic [NCH-1:0]   smp_glitch
);
  logic tick;
  logic per_one;
  logic primed_q;
  logic mask;

  tsamp_divider #(.PER_W(PER_W)) u_div (
    .clk(clk), .rst_n(rst_n), .period(period), .tick(tick), .per_one(per_one)
  );

  assign mask = !primed_q || per_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= tick;
      if (tick) primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    tsamp_chan u_chan (
      .clk(clk), .rst_n(rst_n), .din_bit(din[i]), .tick(tick), .mask(mask),
      .smp_bit(smp_data[i]), .glitch_bit(smp_glitch[i])
    );
  end

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> smp_valid);
  // R2
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !smp_valid);
  // R8
  per_one_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && per_one) |=> (smp_glitch == '0));
  // R9
  first_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !primed_q) |=> (smp_glitch == '0));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(smp_data) && $stable(smp_glitch)));
endmodule

// File: tb/tsamp_top_tb.sv
module tsamp_top_tb;
  localparam int NCH = 4;
  localparam int PER_W = 4;

  typedef struct {
    logic [NCH-1:0] d;
    logic [NCH-1:0] g;
    string          tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PER_W-1:0] period = 4'd4;
  logic [NCH-1:0] din = '0;
  logic smp_valid;
  logic [NCH-1:0] smp_data, smp_glitch;

  int checks = 0;
  int fails = 0;
  exp_t exp_q[$];
  logic [NCH-1:0] b_ref = '0;
  bit first_pending = 1'b1;
  bit mon_en = 1'b0;
  bit have_prev = 1'b0;
  logic [NCH-1:0] prev_d, prev_g;

  always #4 clk = ~clk;

  tsamp_top #(.NCH(NCH), .PER_W(PER_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .period(period), .din(din),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_glitch(smp_glitch)
  );

  // driver: one sample period, values listed lowest nibble first
  task automatic run_period(input logic [PER_W-1:0] prog, input int eff,
                            input logic [63:0] seq, input string tag);
    logic [NCH-1:0] v;
    logic [NCH-1:0] prev;
    int n [NCH];
    exp_t e;
    period = prog;
    prev = b_ref;
    for (int c = 0; c < NCH; c++) n[c] = 0;
    for (int j = 0; j < eff; j++) begin
      v = seq[j*NCH +: NCH];
      din = v;
      for (int c = 0; c < NCH; c++) if (v[c] != prev[c]) n[c]++;
      prev = v;
      if (j == eff - 1) begin
        e.d = v;
        e.tag = tag;
        for (int c = 0; c < NCH; c++) begin
          if (first_pending || eff == 1) e.g[c] = 1'b0;
          else if (v[c] != b_ref[c]) e.g[c] = (n[c] >= 2);
          else e.g[c] = (n[c] >= 1);
        end
        exp_q.push_back(e);
        b_ref = v;
        first_pending = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  // monitor: compare strobed results, check hold between strobes
  always @(negedge clk) begin
    if (mon_en) begin
      if (smp_valid) begin
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2: unexpected strobe data=%h glitch=%h expected no strobe",
                   smp_data, smp_glitch);
        end else begin
          e = exp_q.pop_front();
          if (smp_data !== e.d || smp_glitch !== e.g) begin
            fails++;
            $display("FAIL %s: data=%h glitch=%h expected data=%h glitch=%h",
                     e.tag, smp_data, smp_glitch, e.d, e.g);
          end
        end
      end else if (have_prev) begin
        checks++;
        if (smp_data !== prev_d || smp_glitch !== prev_g) begin
          fails++;
          $display("FAIL R11: data=%h glitch=%h expected data=%h glitch=%h",
                   smp_data, smp_glitch, prev_d, prev_g);
        end
      end
      prev_d = smp_data;
      prev_g = smp_glitch;
      have_prev = 1'b1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (smp_valid !== 1'b0 || smp_data !== '0 || smp_glitch !== '0) begin
      fails++;
      $display("FAIL R1: valid=%b data=%h glitch=%h expected 0 0 0",
               smp_valid, smp_data, smp_glitch);
    end
    rst_n = 1'b1;
    mon_en = 1'b1;
    // R9: pulse inside the first period is not flagged
    run_period(4'd4, 4, 64'h0010, "R9");
    run_period(4'd4, 4, 64'h0000, "R3");
    // R5: narrow pulse on channel 0, level unchanged
    run_period(4'd4, 4, 64'h0010, "R5");
    // R4: single step
    run_period(4'd4, 4, 64'h1110, "R4");
    // R6: from 1 via 0,1,0 -> changed plus extra activity
    run_period(4'd4, 4, 64'h0010, "R6");
    // R7: transition exactly on the sample edge, then a flat period
    run_period(4'd4, 4, 64'h1000, "R7");
    run_period(4'd4, 4, 64'h1111, "R7");
    // R10: mixed channel behaviours in one period
    run_period(4'd4, 4, 64'hDD39, "R10");
    // R8: period of one with toggling inputs
    run_period(4'd1, 1, 64'hF, "R8");
    run_period(4'd1, 1, 64'h0, "R8");
    run_period(4'd1, 1, 64'hF, "R8");
    // R2: zero setting acts as one
    run_period(4'd0, 1, 64'h5, "R2");
    run_period(4'd0, 1, 64'hA, "R2");
    // R5: period two, every channel pulses and returns
    run_period(4'd2, 2, 64'hA5, "R5");
    // R2: longer period, R3 data capture
    run_period(4'd7, 7, 64'h3333_330, "R2");
    run_period(4'd3, 3, 64'hC63, "R3");
    #1;
    mon_en = 1'b0;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d strobes missing, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule